// File: doc/BRIEF.md
# Thread Context Swap Engine

The engine moves hardware thread contexts between a processor core's register file and external memory on behalf of a software scheduler. Every hardware context owns two protected address registers. The image pointer says where the running thread's state is parked. The next pointer says where the state of the thread that should run next is found. When a context is suspended, the engine streams its program counter and sixteen general purpose registers out to the image area. Only after that does it fetch the replacement state from the next area into the same hardware context. The context is allowed to run again once the last word has arrived.

A context is suspended for one of three reasons. It uses up its processing slice, which is counted in retired instructions. It blocks waiting for input. Or the scheduler thread, running as a privileged system thread, writes its choice into its own next pointer and then yields. Only a system thread may change the protected pointers.

Suspensions that arrive while a swap is in progress are remembered and served afterwards, lowest context index first. Both memory channels use valid/ready. The write channel carries one word per beat together with its address. A beat is transferred on a cycle where valid and ready are both high. While ready is low, the engine holds valid, address and data unchanged. The read side has two parts. A command channel carries the base address, and the engine holds valid and address until ready. A response channel carries seventeen data beats, and the engine raises its ready only while it waits for those beats. Back-pressure on either channel stretches a swap but does not change what is moved.

Top module: `tcs_engine`

## Requirements
- R1: After reset, busy is low, every run enable is high, no memory channel is valid, no register file write is issued, and both pointers of every context read back as zero.
- R2: A pointer write with the system flag set updates the selected pointer of the selected context (select 0 = image pointer, 1 = next pointer), visible on the read-back port from the next cycle.
- R3: A pointer write with the system flag low leaves both pointers unchanged and raises the protection error output for exactly one cycle, in the cycle after the write.
- R4: A save sends 17 words to consecutive word addresses starting at the image pointer: the program counter (index 0) first, then general registers r0..r15 (indices 1..16).
- R5: No read command is issued for a swap until all 17 words of its save have been accepted, and no write beat is offered while a load is under way.
- R6: The load issues a single read command at the next pointer and writes the 17 returned beats into the same context at indices 0..16 in arrival order. The context's run enable stays low until the last beat has been accepted.
- R7: When a swap completes, the image pointer of that context takes the value of its next pointer.
- R8: With a nonzero slice budget, the retirement that brings a running context's count up to the budget suspends it (cause code 1). Retirements of a suspended context are not counted. A budget of 0 disables slice suspension. The count restarts at zero when the context's swap completes.
- R9: A blocking wait suspends the named context at once, whatever budget remains (cause code 2).
- R10: A yield suspends the named context (cause code 3). The done pulse reports the context and the cause. A request for a context that is already suspended is dropped.
- R11: Busy goes high in the cycle after a suspension request and stays high until the swap finishes. With no back-pressure and a read response that starts the cycle after the command is accepted, the one-cycle done pulse shows after the 37th clock edge counted from the edge that samples the request, and busy falls in that same cycle.
- R12: Requests that arrive while busy are held and served after the current swap, lowest context index first, and busy stays high between them.
- R13: While write or read-command ready is low, the engine keeps valid, address and data stable. Stalls only lengthen a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_valid | input | 1 | Protected pointer write strobe |
| pw_sys | input | 1 | Writer is a system thread |
| pw_ctx | input | 2 | Context addressed by the pointer write |
| pw_sel | input | 1 | 0 = image pointer, 1 = next pointer |
| pw_data | input | 16 | Pointer write value |
| prot_err | output | 1 | One-cycle flag for a refused pointer write |
| pr_ctx | input | 2 | Pointer read-back context |
| pr_sel | input | 1 | Pointer read-back select |
| pr_data | output | 16 | Pointer read-back value |
| slice_budget | input | 16 | Instructions per processing slice, 0 = unlimited |
| retire_valid | input | 1 | One instruction retired |
| retire_ctx | input | 2 | Context that retired it |
| wait_valid | input | 1 | Blocking-wait suspension request |
| wait_ctx | input | 2 | Context that blocks |
| yield_valid | input | 1 | Self-suspend request |
| yield_ctx | input | 2 | Context that yields |
| busy | output | 1 | A suspension is pending or a swap is in progress |
| run_en | output | 4 | Per-context permission to execute |
| sw_done | output | 1 | One-cycle pulse when a swap completes |
| sw_ctx | output | 2 | Context of the completed swap |
| sw_cause | output | 2 | Cause of the completed swap (1 slice, 2 wait, 3 yield) |
| rf_rd_ctx | output | 2 | Register file read context |
| rf_rd_idx | output | 5 | Register file read index (0 = PC, 1..16 = r0..r15) |
| rf_rd_data | input | 32 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write enable |
| rf_wr_ctx | output | 2 | Register file write context |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| wr_valid | output | 1 | Save beat valid |
| wr_ready | input | 1 | Memory accepts save beat |
| wr_addr | output | 16 | Save beat word address |
| wr_data | output | 32 | Save beat data |
| rc_valid | output | 1 | Read command valid |
| rc_ready | input | 1 | Memory accepts read command |
| rc_addr | output | 16 | Read command base word address |
| rd_valid | input | 1 | Read response beat valid |
| rd_ready | output | 1 | Engine accepts read response beat |
| rd_data | input | 32 | Read response data |

## Verification
Each result is due at a fixed edge. The protection flag and the busy rise show one edge after the stimulus. A retirement that uses up the budget makes busy high after that same edge. A swap without stalls finishes after edge 37, counted from the edge that samples the request. The bench drives inputs at the falling edge and samples at the next falling edge. It counts edges up to the done pulse and compares that count exactly in the stall-free case. With stalls it only requires the count to be larger. The memory and register contents are compared after done, against snapshots taken before the request.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    CS_NONE  = 2'd0,
    CS_SLICE = 2'd1,
    CS_WAIT  = 2'd2,
    CS_YIELD = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_SAVE,
    MV_LREQ,
    MV_LDAT
  } mv_state_e;
endpackage

// File: rtl/tcs_guard.sv
module tcs_guard #(
  parameter int NCTX = 4,
  parameter int AW   = 16,
  parameter int CW   = $clog2(NCTX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pw_valid,
  input  logic                     pw_sys,
  input  logic [CW-1:0]            pw_ctx,
  input  logic                     pw_sel,
  input  logic [AW-1:0]            pw_data,
  input  logic [CW-1:0]            pr_ctx,
  input  logic                     pr_sel,
  input  logic                     relink,
  input  logic [CW-1:0]            relink_ctx,
  output logic [NCTX-1:0][AW-1:0]  img_vec,
  output logic [NCTX-1:0][AW-1:0]  nxt_vec,
  output logic [AW-1:0]            pr_data,
  output logic                     prot_err
);
  logic [NCTX-1:0][AW-1:0] img_q, nxt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q    <= '0;
      nxt_q    <= '0;
      prot_err <= 1'b0;
    end else begin
      prot_err <= pw_valid && !pw_sys;
      for (int c = 0; c < NCTX; c++) begin
        if (relink && relink_ctx == CW'(c))
          img_q[c] <= nxt_q[c];
        if (pw_valid && pw_sys && pw_ctx == CW'(c)) begin
          if (pw_sel) nxt_q[c] <= pw_data;
          else        img_q[c] <= pw_data;
        end
      end
    end
  end

  assign img_vec = img_q;
  assign nxt_vec = nxt_q;
  assign pr_data = pr_sel ? nxt_q[pr_ctx] : img_q[pr_ctx];
endmodule

// File: rtl/tcs_slice.sv
module tcs_slice #(
  parameter int NCTX = 4,
  parameter int BW   = 16,
  parameter int CW   = $clog2(NCTX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BW-1:0]   budget,
  input  logic            retire_valid,
  input  logic [CW-1:0]   retire_ctx,
  input  logic [NCTX-1:0] runnable,
  input  logic            clr,
  input  logic [CW-1:0]   clr_ctx,
  output logic [NCTX-1:0] expire
);
  logic [NCTX-1:0][BW-1:0] cnt_q;
  logic [NCTX-1:0]         hit;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [BW:0] nxt_cnt;
    assign hit[c]    = retire_valid && retire_ctx == CW'(c) && runnable[c];
    assign nxt_cnt   = {1'b0, cnt_q[c]} + (BW+1)'(1);
    assign expire[c] = hit[c] && (budget != '0) && (nxt_cnt >= {1'b0, budget});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      for (int c = 0; c < NCTX; c++) begin
        if (clr && clr_ctx == CW'(c)) cnt_q[c] <= '0;
        else if (hit[c])              cnt_q[c] <= cnt_q[c] + BW'(1);
      end
    end
  end
endmodule

// File: rtl/tcs_mover.sv
module tcs_mover
  import tcs_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int NW   = 17,
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int CW   = $clog2(NCTX),
  parameter int IW   = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_ctx,
  input  logic [AW-1:0] img_addr,
  input  logic [AW-1:0] nxt_addr,
  output logic          idle,
  output logic          fin,
  output logic [CW-1:0] fin_ctx,
  output logic [CW-1:0] rf_rd_ctx,
  output logic [IW-1:0] rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_we,
  output logic [CW-1:0] rf_wr_ctx,
  output logic [IW-1:0] rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rc_valid,
  input  logic          rc_ready,
  output logic [AW-1:0] rc_addr,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [DW-1:0] rd_data
);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  mv_state_e     st;
  logic [IW-1:0] beat;
  logic [CW-1:0] ctx;
  logic [AW-1:0] base_img, base_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= MV_IDLE;
      beat     <= '0;
      ctx      <= '0;
      base_img <= '0;
      base_nxt <= '0;
    end else begin
      unique case (st)
        MV_IDLE: if (start) begin
          st       <= MV_SAVE;
          ctx      <= start_ctx;
          base_img <= img_addr;
          base_nxt <= nxt_addr;
          beat     <= '0;
        end
        MV_SAVE: if (wr_ready) begin
          if (beat == LAST) begin
            beat <= '0;
            st   <= MV_LREQ;
          end else begin
            beat <= beat + IW'(1);
          end
        end
        MV_LREQ: if (rc_ready) st <= MV_LDAT;
        MV_LDAT: if (rd_valid) begin
          if (beat == LAST) begin
            beat <= '0;
            st   <= MV_IDLE;
          end else begin
            beat <= beat + IW'(1);
          end
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  assign idle       = (st == MV_IDLE);
  assign fin        = (st == MV_LDAT) && rd_valid && (beat == LAST);
  assign fin_ctx    = ctx;

  assign rf_rd_ctx  = ctx;
  assign rf_rd_idx  = beat;
  assign wr_valid   = (st == MV_SAVE);
  assign wr_addr    = base_img + AW'(beat);
  assign wr_data    = rf_rd_data;

  assign rc_valid   = (st == MV_LREQ);
  assign rc_addr    = base_nxt;

  assign rd_ready   = (st == MV_LDAT);
  assign rf_we      = (st == MV_LDAT) && rd_valid;
  assign rf_wr_ctx  = ctx;
  assign rf_wr_idx  = beat;
  assign rf_wr_data = rd_data;
endmodule

// File: rtl/tcs_engine.sv
module tcs_engine
  import tcs_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int NGPR = 16,
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int BW   = 16,
  parameter int CW   = $clog2(NCTX),
  parameter int NW   = NGPR + 1,
  parameter int IW   = $clog2(NW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pw_valid,
  input  logic            pw_sys,
  input  logic [CW-1:0]   pw_ctx,
  input  logic            pw_sel,
  input  logic [AW-1:0]   pw_data,
  output logic            prot_err,
  input  logic [CW-1:0]   pr_ctx,
  input  logic            pr_sel,
  output logic [AW-1:0]   pr_data,
  input  logic [BW-1:0]   slice_budget,
  input  logic            retire_valid,
  input  logic [CW-1:0]   retire_ctx,
  input  logic            wait_valid,
  input  logic [CW-1:0]   wait_ctx,
  input  logic            yield_valid,
  input  logic [CW-1:0]   yield_ctx,
  output logic            busy,
  output logic [NCTX-1:0] run_en,
  output logic            sw_done,
  output logic [CW-1:0]   sw_ctx,
  output logic [1:0]      sw_cause,
  output logic [CW-1:0]   rf_rd_ctx,
  output logic [IW-1:0]   rf_rd_idx,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            rf_we,
  output logic [CW-1:0]   rf_wr_ctx,
  output logic [IW-1:0]   rf_wr_idx,
  output logic [DW-1:0]   rf_wr_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            rc_valid,
  input  logic            rc_ready,
  output logic [AW-1:0]   rc_addr,
  input  logic            rd_valid,
  output logic            rd_ready,
  input  logic [DW-1:0]   rd_data
);
  logic [NCTX-1:0]          pend;
  logic [NCTX-1:0][1:0]     cause_q;
  logic [NCTX-1:0]          expire, req_wait, req_yield;
  logic [NCTX-1:0][AW-1:0]  img_vec, nxt_vec;
  logic                     mv_idle, fin, found, start;
  logic [CW-1:0]            fin_ctx, pick;

  tcs_guard #(.NCTX(NCTX), .AW(AW), .CW(CW)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .pw_valid(pw_valid), .pw_sys(pw_sys), .pw_ctx(pw_ctx),
    .pw_sel(pw_sel), .pw_data(pw_data),
    .pr_ctx(pr_ctx), .pr_sel(pr_sel),
    .relink(fin), .relink_ctx(fin_ctx),
    .img_vec(img_vec), .nxt_vec(nxt_vec),
    .pr_data(pr_data), .prot_err(prot_err)
  );

  tcs_slice #(.NCTX(NCTX), .BW(BW), .CW(CW)) u_slice (
    .clk(clk), .rst_n(rst_n),
    .budget(slice_budget),
    .retire_valid(retire_valid), .retire_ctx(retire_ctx),
    .runnable(~pend),
    .clr(fin), .clr_ctx(fin_ctx),
    .expire(expire)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_req
    assign req_wait[c]  = wait_valid  && wait_ctx  == CW'(c);
    assign req_yield[c] = yield_valid && yield_ctx == CW'(c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      cause_q <= '0;
    end else begin
      for (int c = 0; c < NCTX; c++) begin
        if (pend[c]) begin
          if (fin && fin_ctx == CW'(c)) begin
            pend[c]    <= 1'b0;
            cause_q[c] <= CS_NONE;
          end
        end else if (req_wait[c]) begin
          pend[c]    <= 1'b1;
          cause_q[c] <= CS_WAIT;
        end else if (req_yield[c]) begin
          pend[c]    <= 1'b1;
          cause_q[c] <= CS_YIELD;
        end else if (expire[c]) begin
          pend[c]    <= 1'b1;
          cause_q[c] <= CS_SLICE;
        end
      end
    end
  end

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NCTX; i++) begin
      if (pend[i] && !found) begin
        pick  = CW'(i);
        found = 1'b1;
      end
    end
  end

  assign start = mv_idle && found;

  tcs_mover #(.NCTX(NCTX), .NW(NW), .DW(DW), .AW(AW), .CW(CW), .IW(IW)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_ctx(pick),
    .img_addr(img_vec[pick]), .nxt_addr(nxt_vec[pick]),
    .idle(mv_idle), .fin(fin), .fin_ctx(fin_ctx),
    .rf_rd_ctx(rf_rd_ctx), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_ctx(rf_wr_ctx), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rc_valid(rc_valid), .rc_ready(rc_ready), .rc_addr(rc_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_done  <= 1'b0;
      sw_ctx   <= '0;
      sw_cause <= '0;
    end else begin
      sw_done <= fin;
      if (fin) begin
        sw_ctx   <= fin_ctx;
        sw_cause <= cause_q[fin_ctx];
      end
    end
  end

  assign busy   = |pend;
  assign run_en = ~pend;
endmodule

// File: rtl/tcs_engine_chk.sv
module tcs_engine_chk #(
  parameter int NCTX = 4,
  parameter int NW   = 17,
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int CW   = $clog2(NCTX)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [NCTX-1:0] run_en,
  input logic            sw_done,
  input logic [CW-1:0]   sw_ctx,
  input logic            prot_err,
  input logic            pw_valid,
  input logic            pw_sys,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            rc_valid,
  input logic            rc_ready,
  input logic [AW-1:0]   rc_addr,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic            rf_we
);
  localparam int SCW = $clog2(NW + 1);
  logic [SCW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    scnt <= '0;
    else if (rc_valid && rc_ready) scnt <= '0;
    else if (wr_valid && wr_ready) scnt <= scnt + SCW'(1);
  end

  AST_PROT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> $past(pw_valid && !pw_sys)); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R13
  AST_RC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid && !rc_ready |=> rc_valid && $stable(rc_addr)); // R13
  AST_SAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid |-> scnt == SCW'(NW)); // R5
  AST_NO_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && (rc_valid || rd_ready))); // R5
  AST_LOAD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rd_valid && rd_ready); // R6
  AST_DONE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> run_en[sw_ctx]); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sw_done); // R11
endmodule

bind tcs_engine tcs_engine_chk #(.NCTX(NCTX), .NW(NW), .DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .run_en(run_en),
  .sw_done(sw_done), .sw_ctx(sw_ctx),
  .prot_err(prot_err), .pw_valid(pw_valid), .pw_sys(pw_sys),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rc_valid(rc_valid), .rc_ready(rc_ready), .rc_addr(rc_addr),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rf_we(rf_we)
);

// File: tb/sim_tcs_engine.sv
`timescale 1ns/1ps
module sim_tcs_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        pw_valid = 0, pw_sys = 0, pw_sel = 0;
  logic [1:0]  pw_ctx = 0;
  logic [15:0] pw_data = 0;
  logic        prot_err;
  logic [1:0]  pr_ctx = 0;
  logic        pr_sel = 0;
  logic [15:0] pr_data;
  logic [15:0] slice_budget = 0;
  logic        retire_valid = 0, wait_valid = 0, yield_valid = 0;
  logic [1:0]  retire_ctx = 0, wait_ctx = 0, yield_ctx = 0;
  logic        busy, sw_done, rf_we, wr_valid, rc_valid, rd_ready;
  logic [3:0]  run_en;
  logic [1:0]  sw_ctx, sw_cause, rf_rd_ctx, rf_wr_ctx;
  logic [4:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, wr_data, rd_data;
  logic [15:0] wr_addr, rc_addr;
  logic        wr_ready, rc_ready, rd_valid;

  logic [31:0] mem [0:255];
  logic [31:0] rf  [0:3][0:16];
  logic [31:0] snap_mem [0:255];
  logic [31:0] snap_rf  [0:3][0:16];
  logic        wr_gap = 0, rd_gap = 0;
  logic [7:0]  cyc;
  logic        r_act;
  logic [15:0] r_base;
  logic [4:0]  r_k;
  int tests = 0, fails = 0;

  tcs_engine u0 (.*);

  assign rf_rd_data = rf[rf_rd_ctx][rf_rd_idx];
  assign wr_ready   = !wr_gap || cyc[0];
  assign rc_ready   = 1'b1;
  assign rd_valid   = r_act && (!rd_gap || cyc[1]);
  assign rd_data    = mem[8'(r_base + 16'(r_k))];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0;
      r_act <= 0; r_base <= 0; r_k <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= {8'hA5, 8'(i), 16'(i * 7 + 3)};
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 17; k++) rf[c][k] <= {8'(8'hC0 + c), 8'(k), 16'hBEEF};
    end else begin
      cyc <= cyc + 1;
      if (wr_valid && wr_ready) mem[wr_addr[7:0]] <= wr_data;
      if (rf_we) rf[rf_wr_ctx][rf_wr_idx] <= rf_wr_data;
      if (rc_valid && rc_ready) begin
        r_act <= 1; r_base <= rc_addr; r_k <= 0;
      end else if (rd_valid && rd_ready) begin
        r_k <= r_k + 1;
        if (r_k == 16) r_act <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic take_snap();
    for (int i = 0; i < 256; i++) snap_mem[i] = mem[i];
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 17; k++) snap_rf[c][k] = rf[c][k];
  endtask

  task automatic pw(input bit sys, input logic [1:0] c, input bit sel, input logic [15:0] d);
    pw_valid = 1; pw_sys = sys; pw_ctx = c; pw_sel = sel; pw_data = d;
    @(negedge clk);
    pw_valid = 0; pw_sys = 0;
  endtask

  task automatic read_ptr(input logic [1:0] c, input bit sel, output logic [15:0] v);
    pr_ctx = c; pr_sel = sel; #0.5; v = pr_data;
  endtask

  task automatic retire(input logic [1:0] c);
    retire_valid = 1; retire_ctx = c;
    @(negedge clk);
    retire_valid = 0;
  endtask

  task automatic wait_done(output int n, output logic [1:0] c, output logic [1:0] cs);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      wait_valid = 0; yield_valid = 0;
    end while (!sw_done && n < 2000);
    c = sw_ctx; cs = sw_cause;
  endtask

  task automatic verify(input logic [1:0] c, input logic [15:0] img, input logic [15:0] nxt, input string req);
    int bs = 0, bl = 0;
    logic [15:0] v;
    for (int k = 0; k < 17; k++) begin
      if (mem[8'(img + 16'(k))] != snap_rf[c][k]) bs++;
      if (rf[c][k] != snap_mem[8'(nxt + 16'(k))]) bl++;
    end
    chk(bs == 0, "R4", {req, " saved words PC then r0..r15 at image+k"}, bs, 0);
    chk(bl == 0, "R6", {req, " loaded words into context"}, bl, 0);
    read_ptr(c, 0, v);
    chk(v == nxt, "R7", {req, " image pointer relinked"}, v, nxt);
    chk(run_en[c], "R6", {req, " run enable back after load"}, run_en[c], 1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(run_en == 4'hF, "R1", "run_en after reset", run_en, 4'hF);
    chk(!wr_valid && !rc_valid && !rf_we, "R1", "channels idle", {wr_valid, rc_valid, rf_we}, 0);
    read_ptr(2, 1, v);
    chk(v == 0, "R1", "next pointer reset", v, 0);
  endtask

  task automatic t_protect();
    logic [15:0] v;
    pw(1, 1, 0, 16'h0000);
    pw(1, 1, 1, 16'h0020);
    read_ptr(1, 1, v);
    chk(v == 16'h20, "R2", "system write of next pointer", v, 16'h20);
    pw_valid = 1; pw_sys = 0; pw_ctx = 1; pw_sel = 1; pw_data = 16'h0099;
    @(negedge clk);
    pw_valid = 0;
    chk(prot_err == 1, "R3", "protection flag one cycle after write", prot_err, 1);
    read_ptr(1, 1, v);
    chk(v == 16'h20, "R3", "refused write left next pointer", v, 16'h20);
    @(negedge clk);
    chk(prot_err == 0, "R3", "protection flag lasts one cycle", prot_err, 0);
  endtask

  task automatic t_yield();
    int n = 0;
    bit early = 0;
    logic [1:0] c, cs;
    take_snap();
    yield_valid = 1; yield_ctx = 1;
    @(negedge clk);
    n = 1;
    yield_valid = 0;
    chk(busy == 1, "R11", "busy the cycle after yield", busy, 1);
    chk(run_en[1] == 0, "R10", "yielding context stopped", run_en[1], 0);
    while (!sw_done && n < 2000) begin
      if (run_en[1]) early = 1;
      @(negedge clk);
      n++;
    end
    c = sw_ctx; cs = sw_cause;
    chk(!early, "R6", "run enable held low during swap", early, 0);
    chk(n == 37, "R11", "swap latency in edges", n, 37);
    chk(busy == 0, "R11", "busy falls with done", busy, 0);
    chk(c == 1 && cs == 3, "R10", "done context and yield cause", {c, cs}, {2'd1, 2'd3});
    verify(1, 16'h0000, 16'h0020, "yield");
  endtask

  task automatic t_wait_stall();
    int n;
    logic [1:0] c, cs;
    pw(1, 2, 0, 16'h0040);
    pw(1, 2, 1, 16'h0060);
    slice_budget = 16'd100;
    for (int i = 0; i < 3; i++) retire(2);
    take_snap();
    wr_gap = 1; rd_gap = 1;
    wait_valid = 1; wait_ctx = 2;
    wait_done(n, c, cs);
    wr_gap = 0; rd_gap = 0;
    chk(c == 2 && cs == 2, "R9", "wait suspends despite budget left", {c, cs}, {2'd2, 2'd2});
    chk(n > 37 && n < 2000, "R13", "stalls only lengthen the swap", n, 38);
    verify(2, 16'h0040, 16'h0060, "stalled wait");
  endtask

  task automatic t_slice();
    int n;
    logic [1:0] c, cs;
    pw(1, 0, 0, 16'h0080);
    pw(1, 0, 1, 16'h00A0);
    slice_budget = 16'd5;
    for (int i = 0; i < 4; i++) retire(0);
    chk(busy == 0, "R8", "no suspension below budget", busy, 0);
    take_snap();
    retire(0);
    chk(busy == 1 && run_en[0] == 0, "R8", "budget reached suspends", {busy, run_en[0]}, 2'b10);
    retire(0);
    wait_done(n, c, cs);
    chk(c == 0 && cs == 1, "R8", "slice cause reported", {c, cs}, {2'd0, 2'd1});
    verify(0, 16'h0080, 16'h00A0, "slice");
    for (int i = 0; i < 4; i++) retire(0);
    chk(busy == 0, "R8", "count restarted after swap", busy, 0);
    slice_budget = 16'd0;
    for (int i = 0; i < 10; i++) retire(3);
    chk(busy == 0, "R8", "zero budget never suspends", busy, 0);
  endtask

  task automatic t_queue();
    int n = 0, nd = 0;
    bit gap = 0;
    logic [1:0] order [0:2];
    logic [1:0] causes [0:2];
    pw(1, 1, 0, 16'h00C0); pw(1, 1, 1, 16'h00E0);
    pw(1, 0, 0, 16'h0000); pw(1, 0, 1, 16'h0020);
    pw(1, 3, 0, 16'h0040); pw(1, 3, 1, 16'h0060);
    take_snap();
    wait_valid = 1; wait_ctx = 3; yield_valid = 1; yield_ctx = 1;
    @(negedge clk);
    wait_valid = 0; yield_valid = 0;
    repeat (4) @(negedge clk);
    yield_valid = 1; yield_ctx = 0;
    @(negedge clk);
    yield_valid = 0;
    yield_valid = 1; yield_ctx = 1;
    @(negedge clk);
    yield_valid = 0;
    while (nd < 3 && n < 3000) begin
      if (sw_done) begin
        order[nd] = sw_ctx; causes[nd] = sw_cause; nd++;
        if (nd < 3 && !busy) gap = 1;
      end else if (!busy) gap = 1;
      if (nd < 3) begin @(negedge clk); n++; end
    end
    chk(nd == 3, "R12", "three queued swaps finished", nd, 3);
    chk(order[0] == 1 && order[1] == 0 && order[2] == 3, "R12", "service order 1,0,3",
        {order[0], order[1], order[2]}, {2'd1, 2'd0, 2'd3});
    chk(causes[0] == 3 && causes[2] == 2, "R10", "queued causes kept",
        {causes[0], causes[2]}, {2'd3, 2'd2});
    chk(!gap, "R12", "busy held across queued swaps", gap, 0);
    chk(busy == 0, "R10", "repeat yield for suspended context dropped", busy, 0);
    verify(0, 16'h0000, 16'h0020, "queued ctx0");
    verify(3, 16'h0040, 16'h0060, "queued ctx3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_yield();
    t_wait_stall();
    t_slice();
    t_queue();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule